// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Bank

This block holds the programming state of a two-channel serial controller. Each channel has two byte addresses: a control address and a data address. The control address reaches sixteen write registers and sixteen read registers one at a time. The target is chosen by a pointer held in the channel's register 0. After every control access to a register other than 0, that pointer returns to zero, so software always writes the pointer first and then the target register.

The block also applies the side effects the rest of the controller relies on:

- Two configuration registers are shared by the channels.
- A few read registers echo the last value written to the same-numbered write register.
- Programming the modem control register raises the carrier-detect and clear-to-send status bits.
- A transmit-ready flag and an all-sent flag follow the transmit holding byte.
- A command written to register 0 is sent to the interrupt logic as a one-cycle strobe together with its code.

Reads of the data address return the head of an external receive buffer and pop it. Writes to the data address hand a byte to the line transmitter through a valid/ready pair.

Top module: `sio_regbank`

## Requirements
- R1: Address bit 1 selects the channel (0 = A, 1 = B) and address bit 0 selects data (1) or control (0). A control access targets the index formed from the channel's register 0: the low three bits, plus 8 when bits 5:3 hold 3'b001. A control read returns that read register on `bus_rdata` in the same cycle as the strobe. A control write lands at the next clock edge.
- R2: After a control read or write of a nonzero index, the pointer bits 5:0 of that channel's register 0 are cleared, so the next control access reaches index 0. Accesses at index 0 leave the pointer as written.
- R3: A control write to index 2 or index 9 on either channel updates that register in both channels. Both channels' copies of register 9 drive `int_ctl` (A in bits 7:0, B in bits 15:8), and a write to index 2 also sets read register 2 of both channels.
- R4: A control write to index 12, 13 or 15 is also stored in the same-numbered read register of that channel. Writes to other nonzero indices leave the read registers unchanged.
- R5: A control write to index 5 sets read register 0 bit 3 (carrier detect). If bit 1 of the written byte is 1, it also sets read register 0 bit 5 (clear to send). Both bits stay set until reset.
- R6: After a synchronous active-low reset, in each channel read register 0 is 8'h04 (bit 2 transmit ready), read register 1 is 8'h01 (bit 0 all sent) and read register 2 is 8'h06. Every other register is zero, `tx_valid` is low and `cmd_strobe` is low.
- R7: A data write makes the channel's `tx_valid` high from the next cycle, with the byte on its `tx_data` slice, and clears read register 0 bit 2 and read register 1 bit 1'b0 position (bit 0). A clock edge that sees `tx_valid` and `tx_ready` both high completes the transfer: `tx_valid` drops and both flags are set again. A data write on the same edge wins.
- R8: A control write at index 0 whose bits 5:3 are neither 0 nor 3'b001 is a command. `cmd_strobe` for that channel is high for exactly the following cycle, with `cmd_code` equal to those bits (0 otherwise). Register 0 keeps the written byte with bits 5:3 cleared.
- R9: A data read returns the channel's `rx_head` byte on `bus_rdata` in the same cycle, pulses that channel's `rx_pop` in that cycle, and leaves the pointer unchanged.
- R10: Bit 0 of read register 0 always reads the channel's `rx_avail` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Bit 1 channel, bit 0 data/control |
| bus_wdata | input | DW | Write byte |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_rdata | output | DW | Read byte, valid in the strobe cycle |
| rx_head | input | 2*DW | Receive buffer head, A low, B high |
| rx_avail | input | 2 | Receive buffer non-empty per channel |
| rx_pop | output | 2 | Receive buffer pop per channel |
| tx_data | output | 2*DW | Transmit byte, A low, B high |
| tx_valid | output | 2 | Transmit byte valid per channel |
| tx_ready | input | 2 | Transmitter accepts byte per channel |
| cmd_strobe | output | 2 | Command pulse per channel |
| cmd_code | output | 3 | Code of the pulsed command |
| int_ctl | output | 2*DW | Register 9 copy of each channel |

## Verification
The bench builds the block with its default byte width of 8 and sixteen registers per bank. At that size every pointer encoding can be reached: both halves of the index space through the high-bank code, each shared and echoing register, and command codes at both ends of their range. A behavioural model is compared on every clock against the transmit, command and shared-configuration outputs, and against each read. The sequences cover one channel writing while the other channel's state is watched, a transmit that is held off by `tx_ready`, and a command combined with a pointer in one write.

// File: rtl/sio_pkg.sv
// Shared constants and index helpers for the dual-channel register bank.
// Assumes byte-wide registers (field positions below sit in bits 7:0).
package sio_pkg;
    localparam int DATA_W    = 8;
    localparam int NUM_REGS  = 16;
    localparam int IDX_W     = $clog2(NUM_REGS);
    localparam logic [2:0] HIGH_BANK = 3'b001;
    localparam int ST_RXAV   = 0;
    localparam int ST_TXRDY  = 2;
    localparam int ST_DCD    = 3;
    localparam int ST_CTS    = 5;
    localparam int ST_ALLSNT = 0;
    localparam int MDM_RTS   = 1;
    localparam logic [DATA_W-1:0] VEC_IDLE = 8'h06;
    localparam logic [IDX_W-1:0] IDX_MODEM = 4'd5;
    localparam logic [IDX_W-1:0] IDX_VEC   = 4'd2;
    localparam logic [IDX_W-1:0] IDX_MIC   = 4'd9;

    function automatic logic is_shared(input logic [IDX_W-1:0] idx);
        return (idx == IDX_VEC) || (idx == IDX_MIC);
    endfunction

    function automatic logic is_echo(input logic [IDX_W-1:0] idx);
        return (idx == 4'd2) || (idx == 4'd12) || (idx == 4'd13) || (idx == 4'd15);
    endfunction
endpackage

// File: rtl/sio_tx_hold.sv
// Transmit holding byte for one channel with a valid/ready output.
// Assumes a load and a completed transfer may share an edge; the load wins.
module sio_tx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          ready,
    output logic          valid,
    output logic [DW-1:0] dout,
    output logic          sent
);
    assign sent = valid & ready;

    // Hold the byte until the transmitter takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            dout  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            dout  <= din;
        end else if (sent) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/sio_chan_regs.sv
// Write and read register banks of one channel, with pointer decode.
// Assumes reg_we never targets index 0 (register 0 has its own port).
module sio_chan_regs
    import sio_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NR = NUM_REGS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr0_we,
    input  logic [DW-1:0]    wr0_din,
    input  logic             ptr_clr,
    input  logic             reg_we,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [DW-1:0]    reg_din,
    input  logic             echo_we,
    input  logic             tx_load,
    input  logic             tx_sent,
    input  logic             rx_avail,
    output logic [IDX_W-1:0] ptr,
    output logic [DW-1:0]    rd_data,
    output logic [DW-1:0]    mic
);
    logic [DW-1:0] wr_q [NR];
    logic [DW-1:0] rr_q [NR];

    // Pointer: low three bits, high bank when bits 5:3 hold the select code.
    always_comb begin
        ptr = {wr_q[0][5:3] == HIGH_BANK, wr_q[0][2:0]};
    end

    // Selected read register, receive-available merged live into register 0.
    always_comb begin
        rd_data = rr_q[ptr];
        if (ptr == '0) rd_data[ST_RXAV] = rx_avail;
    end

    assign mic = wr_q[IDX_MIC];

    // Register updates and their status side effects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) begin
                wr_q[i] <= '0;
                rr_q[i] <= '0;
            end
            rr_q[0][ST_TXRDY]  <= 1'b1;
            rr_q[1][ST_ALLSNT] <= 1'b1;
            rr_q[2]            <= VEC_IDLE;
        end else begin
            if (wr0_we)       wr_q[0]      <= wr0_din;
            else if (ptr_clr) wr_q[0][5:0] <= '0;
            if (reg_we)       wr_q[reg_idx] <= reg_din;
            if (echo_we)      rr_q[reg_idx] <= reg_din;
            if (reg_we && reg_idx == IDX_MODEM) begin
                rr_q[0][ST_DCD] <= 1'b1;
                if (reg_din[MDM_RTS]) rr_q[0][ST_CTS] <= 1'b1;
            end
            if (tx_load) begin
                rr_q[0][ST_TXRDY]  <= 1'b0;
                rr_q[1][ST_ALLSNT] <= 1'b0;
            end else if (tx_sent) begin
                rr_q[0][ST_TXRDY]  <= 1'b1;
                rr_q[1][ST_ALLSNT] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sio_regbank.sv
// Dual-channel register bank: decodes the byte bus, routes shared and
// echoed writes between channels, and issues command strobes.
// Assumes bus_wr and bus_rd are never high together; a write wins if they are.
module sio_regbank
    import sio_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_wr,
    input  logic          bus_rd,
    output logic [DW-1:0] bus_rdata,
    input  logic [2*DW-1:0] rx_head,
    input  logic [1:0]    rx_avail,
    output logic [1:0]    rx_pop,
    output logic [2*DW-1:0] tx_data,
    output logic [1:0]    tx_valid,
    input  logic [1:0]    tx_ready,
    output logic [1:0]    cmd_strobe,
    output logic [2:0]    cmd_code,
    output logic [2*DW-1:0] int_ctl
);
    localparam int NCH = 2;

    logic                       ch_sel;
    logic                       is_data;
    logic                       rd_only;
    logic                       is_cmd;
    logic [DW-1:0]              wr0_val;
    logic [NCH-1:0]             ctl_wr, ctl_rd, own_wr, cmd_hit;
    logic [NCH-1:0][IDX_W-1:0]  ptr_idx;
    logic [NCH-1:0][DW-1:0]     chan_rd;

    assign ch_sel  = bus_addr[1];
    assign is_data = bus_addr[0];
    assign rd_only = bus_rd & ~bus_wr;
    assign is_cmd  = (bus_wdata[5:3] != 3'b000) && (bus_wdata[5:3] != HIGH_BANK);
    assign wr0_val = is_cmd ? {bus_wdata[DW-1:6], 3'b000, bus_wdata[2:0]} : bus_wdata;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int OC = NCH - 1 - c;
        logic hit, peer_share, reg_we, echo_we, wr0_we, tx_sent, tx_load;
        logic [IDX_W-1:0] reg_idx;

        assign hit        = (ch_sel == 1'(c));
        assign ctl_wr[c]  = bus_wr & ~is_data & hit;
        assign ctl_rd[c]  = rd_only & ~is_data & hit;
        assign own_wr[c]  = ctl_wr[c] & (ptr_idx[c] != '0);
        assign rx_pop[c]  = rd_only & is_data & hit;
        assign tx_load    = bus_wr & is_data & hit;
        assign peer_share = own_wr[OC] & is_shared(ptr_idx[OC]);
        assign reg_we     = own_wr[c] | peer_share;
        assign reg_idx    = own_wr[c] ? ptr_idx[c] : ptr_idx[OC];
        assign echo_we    = (own_wr[c] & is_echo(ptr_idx[c]))
                          | (peer_share & (ptr_idx[OC] == IDX_VEC));
        assign wr0_we     = ctl_wr[c] & (ptr_idx[c] == '0);
        assign cmd_hit[c] = wr0_we & is_cmd;

        sio_chan_regs #(.DW(DW), .NR(NUM_REGS)) u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr0_we   (wr0_we),
            .wr0_din  (wr0_val),
            .ptr_clr  ((ctl_wr[c] | ctl_rd[c]) & (ptr_idx[c] != '0)),
            .reg_we   (reg_we),
            .reg_idx  (reg_idx),
            .reg_din  (bus_wdata),
            .echo_we  (echo_we),
            .tx_load  (tx_load),
            .tx_sent  (tx_sent),
            .rx_avail (rx_avail[c]),
            .ptr      (ptr_idx[c]),
            .rd_data  (chan_rd[c]),
            .mic      (int_ctl[c*DW +: DW])
        );

        sio_tx_hold #(.DW(DW)) u_tx (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (tx_load),
            .din   (bus_wdata),
            .ready (tx_ready[c]),
            .valid (tx_valid[c]),
            .dout  (tx_data[c*DW +: DW]),
            .sent  (tx_sent)
        );
    end

    // Read mux: receive head on the data address, pointed register otherwise.
    always_comb begin
        bus_rdata = is_data ? rx_head[ch_sel*DW +: DW] : chan_rd[ch_sel];
    end

    // Register the command strobe and its code for the interrupt logic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_strobe <= '0;
            cmd_code   <= '0;
        end else begin
            cmd_strobe <= cmd_hit;
            cmd_code   <= (|cmd_hit) ? bus_wdata[5:3] : 3'b000;
        end
    end
endmodule

// File: rtl/sio_regbank_chk.sv
// Protocol checks for the register bank, bound to the top module.
// Assumes it observes the top's ports and its per-channel pointers.
module sio_regbank_chk #(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      bus_addr,
    input logic            bus_wr,
    input logic            bus_rd,
    input logic [1:0]      tx_valid,
    input logic [1:0]      tx_ready,
    input logic [1:0]      cmd_strobe,
    input logic [2:0]      cmd_code,
    input logic [2*DW-1:0] int_ctl,
    input logic [1:0][3:0] ptr_idx
);
    p_cmd_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_strobe));

    p_cmd_from_ctl_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe != 2'b00) |-> $past(bus_wr && !bus_addr[0]));

    p_cmd_code_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe == 2'b00) |-> (cmd_code == 3'b000));

    p_ptr_home_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && bus_addr == 2'b00 && ptr_idx[0] != 4'd0) |=> (ptr_idx[0] == 4'd0));

    p_ptr_home_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && bus_addr == 2'b10 && ptr_idx[1] != 4'd0) |=> (ptr_idx[1] == 4'd0));

    p_shared_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int_ctl[DW-1:0] == int_ctl[2*DW-1:DW]);

    p_tx_hold_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid[0] && !tx_ready[0]) |=> tx_valid[0]);

    p_tx_load_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'b11) |=> tx_valid[1]);
endmodule

bind sio_regbank sio_regbank_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .cmd_strobe (cmd_strobe),
    .cmd_code   (cmd_code),
    .int_ctl    (int_ctl),
    .ptr_idx    (ptr_idx)
);

// File: tb/sio_regbank_test.sv
module sio_regbank_test;
    localparam int CLK_PERIOD = 10;
    localparam int K_IDLE = 0, K_CWR = 1, K_CRD = 2, K_DWR = 3, K_DRD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [15:0] rx_head = 16'hB2A1;
    logic [1:0]  rx_avail = 2'b00;
    logic [1:0]  rx_pop;
    logic [15:0] tx_data;
    logic [1:0]  tx_valid;
    logic [1:0]  tx_ready = 2'b00;
    logic [1:0]  cmd_strobe;
    logic [2:0]  cmd_code;
    logic [15:0] int_ctl;

    int tests = 0, fails = 0;
    bit cmp_on = 0;

    // Behavioural model state
    logic [7:0] mwr [2][16];
    logic [7:0] mrr [2][16];
    bit         mvalid [2];
    logic [7:0] mtxd [2];
    logic [1:0] e_strobe;
    logic [2:0] e_code;

    sio_regbank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .rx_head(rx_head), .rx_avail(rx_avail), .rx_pop(rx_pop),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .cmd_strobe(cmd_strobe), .cmd_code(cmd_code), .int_ctl(int_ctl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] mptr(input int ch);
        return {mwr[ch][0][5:3] == 3'b001, mwr[ch][0][2:0]};
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < 16; i++) begin
                mwr[c][i] = '0;
                mrr[c][i] = '0;
            end
            mrr[c][0] = 8'h04;
            mrr[c][1] = 8'h01;
            mrr[c][2] = 8'h06;
            mvalid[c] = 0;
            mtxd[c] = '0;
        end
        e_strobe = '0;
        e_code = '0;
    endtask

    // Model one clock edge with the operation presented before it.
    task automatic model_edge(input int kind, input int ch, input logic [7:0] d, input logic [1:0] rdy);
        logic [3:0] p;
        e_strobe = '0;
        e_code = '0;
        for (int c = 0; c < 2; c++) begin
            if (mvalid[c] && rdy[c]) begin
                mvalid[c] = 0;
                mrr[c][0][2] = 1'b1;
                mrr[c][1][0] = 1'b1;
            end
        end
        p = mptr(ch);
        case (kind)
            K_CWR: begin
                if (p == 0) begin
                    if (d[5:3] != 3'b000 && d[5:3] != 3'b001) begin
                        e_strobe[ch] = 1'b1;
                        e_code = d[5:3];
                        mwr[ch][0] = {d[7:6], 3'b000, d[2:0]};
                    end else begin
                        mwr[ch][0] = d;
                    end
                end else begin
                    mwr[ch][p] = d;
                    if (p == 2 || p == 9) mwr[1-ch][p] = d;
                    if (p == 2) mrr[1-ch][2] = d;
                    if (p == 2 || p == 12 || p == 13 || p == 15) mrr[ch][p] = d;
                    if (p == 5) begin
                        mrr[ch][0][3] = 1'b1;
                        if (d[1]) mrr[ch][0][5] = 1'b1;
                    end
                    mwr[ch][0][5:0] = '0;
                end
            end
            K_CRD: if (p != 0) mwr[ch][0][5:0] = '0;
            K_DWR: begin
                mvalid[ch] = 1;
                mtxd[ch] = d;
                mrr[ch][0][2] = 1'b0;
                mrr[ch][1][0] = 1'b0;
            end
            default: ;
        endcase
    endtask

    // One bus cycle: drive, check any read in the cycle, then advance the model.
    task automatic cyc(input int kind, input int ch, input logic [7:0] d, input string tag);
        logic [7:0] exp;
        logic [3:0] p;
        logic [1:0] rdy;
        bus_addr  = {ch[0], (kind == K_DWR || kind == K_DRD)};
        bus_wdata = d;
        bus_wr    = (kind == K_CWR || kind == K_DWR);
        bus_rd    = (kind == K_CRD || kind == K_DRD);
        #1;
        if (kind == K_CRD) begin
            p = mptr(ch);
            exp = mrr[ch][p];
            if (p == 0) exp[0] = rx_avail[ch];
            chk(bus_rdata == exp, tag, bus_rdata, exp);
        end
        if (kind == K_DRD) begin
            exp = rx_head[ch*8 +: 8];
            chk(bus_rdata == exp, tag, bus_rdata, exp);
            chk(rx_pop == (2'b01 << ch), "R9 rx_pop", rx_pop, 2'b01 << ch);
        end else begin
            chk(rx_pop == 2'b00, "R9 rx_pop idle", rx_pop, 0);
        end
        rdy = tx_ready;
        @(posedge clk);
        #1;
        model_edge(kind, ch, d, rdy);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(K_IDLE, 0, 8'h00, "idle");
    endtask

    // Compare registered outputs against the model on every clock.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(tx_valid == {mvalid[1], mvalid[0]}, "R7 tx_valid", tx_valid, {mvalid[1], mvalid[0]});
            if (mvalid[0]) chk(tx_data[7:0] == mtxd[0], "R7 tx_data A", tx_data[7:0], mtxd[0]);
            if (mvalid[1]) chk(tx_data[15:8] == mtxd[1], "R7 tx_data B", tx_data[15:8], mtxd[1]);
            chk(cmd_strobe == e_strobe, "R8 cmd_strobe", cmd_strobe, e_strobe);
            chk(cmd_code == e_code, "R8 cmd_code", cmd_code, e_code);
            chk(int_ctl == {mwr[1][9], mwr[0][9]}, "R3 int_ctl", int_ctl, {mwr[1][9], mwr[0][9]});
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        cmp_on = 1;
        // R6 reset values through the pointer
        cyc(K_CRD, 0, 0, "R6 rr0 A");
        cyc(K_CWR, 0, 8'h01, "R6 ptr");
        cyc(K_CRD, 0, 0, "R6 rr1 A");
        cyc(K_CWR, 1, 8'h02, "R6 ptr");
        cyc(K_CRD, 1, 0, "R6 rr2 B");
        // R2 pointer back at zero after the pointed read
        cyc(K_CRD, 1, 0, "R2 back to rr0");
        // R1 and R4: high bank and echoes
        cyc(K_CWR, 0, 8'h0C, "R1 ptr 12");
        cyc(K_CWR, 0, 8'h5A, "R4 wr12");
        cyc(K_CWR, 0, 8'h0C, "R1 ptr 12");
        cyc(K_CRD, 0, 0, "R4 rr12 echo");
        cyc(K_CWR, 1, 8'h0D, "R1 ptr 13");
        cyc(K_CWR, 1, 8'h33, "R4 wr13");
        cyc(K_CWR, 1, 8'h0D, "R1 ptr 13");
        cyc(K_CRD, 1, 0, "R4 rr13 echo");
        cyc(K_CWR, 0, 8'h0F, "R1 ptr 15");
        cyc(K_CWR, 0, 8'hC3, "R4 wr15");
        cyc(K_CWR, 0, 8'h0F, "R1 ptr 15");
        cyc(K_CRD, 0, 0, "R4 rr15 echo");
        cyc(K_CWR, 0, 8'h03, "R1 ptr 3");
        cyc(K_CWR, 0, 8'hFF, "R4 wr3");
        cyc(K_CWR, 0, 8'h03, "R1 ptr 3");
        cyc(K_CRD, 0, 0, "R4 rr3 not echoed");
        // R3 shared registers
        cyc(K_CWR, 1, 8'h02, "R3 ptr 2");
        cyc(K_CWR, 1, 8'h40, "R3 wr2 from B");
        cyc(K_CWR, 0, 8'h02, "R3 ptr 2");
        cyc(K_CRD, 0, 0, "R3 rr2 A");
        cyc(K_CWR, 1, 8'h09, "R3 ptr 9");
        cyc(K_CWR, 1, 8'h0A, "R3 wr9 from B");
        cyc(K_CWR, 0, 8'h09, "R3 ptr 9");
        cyc(K_CWR, 0, 8'h81, "R3 wr9 from A");
        // R5 modem control side effects
        cyc(K_CWR, 0, 8'h05, "R5 ptr 5");
        cyc(K_CWR, 0, 8'h00, "R5 wr5 no rts");
        cyc(K_CRD, 0, 0, "R5 rr0 dcd");
        cyc(K_CWR, 0, 8'h05, "R5 ptr 5");
        cyc(K_CWR, 0, 8'h02, "R5 wr5 rts");
        cyc(K_CRD, 0, 0, "R5 rr0 cts");
        cyc(K_CRD, 1, 0, "R5 rr0 B untouched");
        // R7 transmit path
        cyc(K_DWR, 0, 8'h41, "R7 load A");
        cyc(K_CRD, 0, 0, "R7 txrdy low");
        cyc(K_CWR, 0, 8'h01, "R7 ptr 1");
        cyc(K_CRD, 0, 0, "R7 allsent low");
        idle(2);
        tx_ready = 2'b01;
        idle(1);
        tx_ready = 2'b00;
        cyc(K_CRD, 0, 0, "R7 txrdy back");
        cyc(K_CWR, 0, 8'h01, "R7 ptr 1");
        cyc(K_CRD, 0, 0, "R7 allsent back");
        cyc(K_DWR, 1, 8'h7E, "R7 load B");
        tx_ready = 2'b10;
        cyc(K_DWR, 1, 8'h7F, "R7 load while sending");
        idle(1);
        tx_ready = 2'b00;
        cyc(K_CRD, 1, 0, "R7 rr0 B after send");
        // R8 commands
        cyc(K_CWR, 0, 8'h18, "R8 cmd 3 A");
        idle(1);
        cyc(K_CWR, 1, 8'h3A, "R8 cmd 7 B with ptr 2");
        cyc(K_CRD, 1, 0, "R8 ptr kept after cmd");
        cyc(K_CWR, 0, 8'h10, "R8 cmd 2 A");
        cyc(K_CWR, 0, 8'h08, "R8 high bank no cmd");
        cyc(K_CRD, 0, 0, "R1 rr8 read");
        // R9 data reads keep the pointer; R10 live receive flag
        cyc(K_CWR, 0, 8'h0C, "R9 ptr 12");
        cyc(K_DRD, 0, 0, "R9 data A");
        cyc(K_CRD, 0, 0, "R9 ptr unchanged");
        rx_head = 16'h5DC4;
        cyc(K_DRD, 1, 0, "R9 data B");
        rx_avail = 2'b10;
        cyc(K_CRD, 1, 0, "R10 rxav B high");
        cyc(K_CRD, 0, 0, "R10 rxav A low");
        rx_avail = 2'b01;
        cyc(K_CRD, 0, 0, "R10 rxav A high");
        idle(2);
        // R6 again after a mid-run reset
        rst_n = 1'b0;
        cmp_on = 0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        model_reset();
        cmp_on = 1;
        cyc(K_CRD, 1, 0, "R6 rr0 B after reset");
        cyc(K_CWR, 0, 8'h02, "R6 ptr 2");
        cyc(K_CRD, 0, 0, "R6 rr2 A after reset");
        idle(2);
        cmp_on = 0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule